// File: doc/BRIEF.md
# Pulse Accumulator Counter

This block keeps a small counter that grows in one of two ways. In event mode it adds one for every qualifying transition of an external input pin. In gated mode it adds one for every pulse of an internal timebase tick, but only while the pin sits at its active gate level. One polarity bit serves both modes. In event mode it picks the rising or the falling edge. In gated mode it picks whether a high or a low pin opens the gate.

The pin passes through a two-flop synchronizer before any decision is made. Software reaches the block through a single 16-bit register. The counter sits in the low byte. The high byte holds the enable, the mode, the polarity, two sticky flags and a read-only copy of the synchronized pin. Byte enables let software update the control byte and the counter separately.

Top module: `pulse_acc`

## Requirements
- R1: After reset the register reads 0x0000 while the pin is low: counter 0, enable, mode, polarity and both flags 0.
- R2: With the enable (bit 14) at 0 the counter does not change, whatever the pin and the tick do.
- R3: In event mode (mode bit 13 = 0) with polarity bit 12 = 1, each rising edge of the synchronized pin adds exactly one. The counter changes three clock edges after the pin changes, and tick pulses have no effect.
- R4: In event mode with polarity 0, each falling edge of the synchronized pin adds exactly one.
- R5: In gated mode (mode = 1), each tick pulse adds one while the gate is open. The gate is open when the pin is high for polarity 0 and low for polarity 1. Ticks outside the gate have no effect.
- R6: An increment at 0xFF wraps the counter to 0x00 and sets the overflow flag (bit 11). The flag stays set until a high-byte write with bit 11 = 1 clears it, and a wrap in the same cycle wins over the clear.
- R7: The event flag (bit 10) is set by each counted edge in event mode, and by the closing of the gate in gated mode. A high-byte write with bit 10 = 1 clears it.
- R8: A write to the low byte loads the counter, and it overrides an increment due in the same cycle.
- R9: Bit 15 reads the synchronized pin level. It follows a pin change after two clock edges, and writes do not affect it.
- R10: Bits 9:8 read 0. Bits 14:12 read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous accumulator input pin |
| tick | input | 1 | One-cycle timebase pulse for gated mode |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 2 | Byte enables: bit 1 high byte, bit 0 counter byte |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Register read value |

## Verification
The counter byte shows a wrong synchronizer or edge state at once. A missing or doubled stage moves the first increment off the third edge after a pin change. A wrong edge history adds a count at the wrong transition, which the count after a pulse train shows. A flag register that fails to hold or to set appears in bits 11:10 on the read right after the wrapping or gate-closing edge. A wrong priority between load and increment leaves the loaded value off by one in the very next cycle.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
   // Fixed bit positions of the high byte; software and the bench decode them
   localparam int unsigned REG_W    = 16;
   localparam int unsigned LO_W     = 8;
   localparam int unsigned B_PIN    = 15;
   localparam int unsigned B_EN     = 14;
   localparam int unsigned B_MODE   = 13;
   localparam int unsigned B_POL    = 12;
   localparam int unsigned B_OVF    = 11;
   localparam int unsigned B_EVF    = 10;

   typedef enum logic {
      MODE_EVENT = 1'b0,
      MODE_GATED = 1'b1
   } acc_mode_e;

   typedef struct packed {
      logic      en;
      acc_mode_e mode;
      logic      pol;
   } acc_ctrl_t;
endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pacc_qual.sv
module pacc_qual
   import pacc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lvl,
   input  logic      tick,
   input  acc_ctrl_t ctrl,
   output logic      inc,
   output logic      evt_flag_set
);
   logic lvl_prev_q;
   logic rise, fall, gate_now, gate_was, gate_close;
   logic ev_hit, gt_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev_q <= 1'b0;
      else        lvl_prev_q <= lvl;
   end

   always_comb begin
      rise       = lvl & ~lvl_prev_q;
      fall       = ~lvl & lvl_prev_q;
      gate_now   = ctrl.pol ? ~lvl : lvl;
      gate_was   = ctrl.pol ? ~lvl_prev_q : lvl_prev_q;
      gate_close = gate_was & ~gate_now;
      ev_hit     = ctrl.pol ? rise : fall;
      gt_hit     = tick & gate_now;
      inc          = 1'b0;
      evt_flag_set = 1'b0;
      if (ctrl.en) begin
         if (ctrl.mode == MODE_EVENT) begin
            inc          = ev_hit;
            evt_flag_set = ev_hit;
         end else begin
            inc          = gt_hit;
            evt_flag_set = gate_close;
         end
      end
   end
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (inc)  cnt_q <= cnt_q + 1'b1;
   end

   assign wrap = inc & ~load & (cnt_q == CNT_MAX);
   assign cnt  = cnt_q;
endmodule

// File: rtl/pulse_acc.sv
module pulse_acc
   import pacc_pkg::*;
#(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        pin_in,
   input  logic        tick,
   input  logic        reg_wr,
   input  logic [1:0]  reg_be,
   input  logic [15:0] reg_wdata,
   output logic [15:0] reg_rdata
);
   localparam int unsigned PAD_W = LO_W - CNT_W;

   if (CNT_W < 1 || CNT_W > LO_W) begin : g_bad_width
      $error("pulse_acc: CNT_W must lie in 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pulse_acc: SYNC_STAGES must be at least 2");
   end

   logic             pin_s;
   acc_ctrl_t        ctrl_q;
   logic             en_q, mode_q;
   logic             ovf_q, evf_q;
   logic             hi_wr, cnt_ld, ovf_clr, evf_clr;
   logic             inc, evt_set, wrap;
   logic [CNT_W-1:0] ld_val, cnt_q;
   logic [LO_W-1:0]  lo_byte;

   assign hi_wr   = reg_wr & reg_be[1];
   assign cnt_ld  = reg_wr & reg_be[0];
   assign ovf_clr = hi_wr & reg_wdata[B_OVF];
   assign evf_clr = hi_wr & reg_wdata[B_EVF];
   assign ld_val  = reg_wdata[CNT_W-1:0];

   pacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '{en: 1'b0, mode: MODE_EVENT, pol: 1'b0};
      end else if (hi_wr) begin
         ctrl_q.en   <= reg_wdata[B_EN];
         ctrl_q.mode <= acc_mode_e'(reg_wdata[B_MODE]);
         ctrl_q.pol  <= reg_wdata[B_POL];
      end
   end

   assign en_q   = ctrl_q.en;
   assign mode_q = ctrl_q.mode;

   pacc_qual u_qual (
      .clk(clk), .rst_n(rst_n), .lvl(pin_s), .tick(tick), .ctrl(ctrl_q),
      .inc(inc), .evt_flag_set(evt_set)
   );

   pacc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(cnt_ld), .load_val(ld_val),
      .inc(inc), .cnt(cnt_q), .wrap(wrap)
   );

   // Setting a flag wins over clearing it in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         evf_q <= 1'b0;
      end else begin
         ovf_q <= wrap    | (ovf_q & ~ovf_clr);
         evf_q <= evt_set | (evf_q & ~evf_clr);
      end
   end

   if (CNT_W == LO_W) begin : g_full
      assign lo_byte = cnt_q;
   end else begin : g_pad
      assign lo_byte = {{PAD_W{1'b0}}, cnt_q};
   end

   assign reg_rdata = {pin_s, ctrl_q.en, ctrl_q.mode, ctrl_q.pol,
                       ovf_q, evf_q, 2'b00, lo_byte};
endmodule

// File: rtl/pacc_chk.sv
module pacc_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt,
   input logic             cnt_ld,
   input logic [CNT_W-1:0] ld_val,
   input logic             en,
   input logic             mode,
   input logic             tick,
   input logic             ovf,
   input logic             ovf_clr
);
   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

   AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !cnt_ld) |=> $stable(cnt));                                  // R2
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_ld |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1))); // R3
   AST_GATE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode && !tick && !cnt_ld) |=> $stable(cnt));                  // R5
   AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == MAXV && !cnt_ld) ##1 (cnt == '0) |-> ovf);                    // R6
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf);                                          // R6
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_ld |=> (cnt == $past(ld_val)));                                  // R8
endmodule

bind pulse_acc pacc_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .cnt_ld(cnt_ld), .ld_val(ld_val),
   .en(en_q), .mode(mode_q), .tick(tick), .ovf(ovf_q), .ovf_clr(ovf_clr)
);

// File: tb/sim_pulse_acc.sv
`timescale 1ns/1ps
module sim_pulse_acc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin_in = 1'b0;
   logic        tick = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_be = 2'b00;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;
   int          n_chk = 0;
   int          n_err = 0;
   bit          done = 0;

   always #10 clk = ~clk;

   pulse_acc u0 (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tick(tick),
      .reg_wr(reg_wr), .reg_be(reg_be), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   // {en, mode, pol, start, pulses[7:0], ticks[7:0], expected[7:0]}
   localparam int NV = 9;
   localparam logic [27:0] VEC [NV] = '{
      {4'b1010, 8'd5, 8'd0, 8'd5},   // event, rising
      {4'b1000, 8'd3, 8'd0, 8'd3},   // event, falling
      {4'b0010, 8'd4, 8'd0, 8'd0},   // disabled
      {4'b1101, 8'd0, 8'd6, 8'd6},   // gated, pin high opens
      {4'b1100, 8'd0, 8'd6, 8'd0},   // gated, pin low closed
      {4'b1110, 8'd0, 8'd7, 8'd7},   // gated inverted, pin low opens
      {4'b1111, 8'd0, 8'd7, 8'd0},   // gated inverted, pin high closed
      {4'b1010, 8'd2, 8'd5, 8'd2},   // event, ticks ignored
      {4'b0101, 8'd0, 8'd5, 8'd0}    // disabled gated
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] be, input logic [15:0] d);
      reg_wr = 1'b1; reg_be = be; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_be = 2'b00;
   endtask

   function automatic logic [15:0] ctl(input logic en, input logic md, input logic pl);
      return {1'b0, en, md, pl, 2'b11, 2'b00, 8'h00};
   endfunction

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         pin_in = ~pin_in; cyc(4);
         pin_in = ~pin_in; cyc(4);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1; cyc(1);
         tick = 1'b0; cyc(3);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 reset value", reg_rdata, 16'h0000);

      // R9 synchronizer latency
      pin_in = 1'b1;
      cyc(1);
      chk("R9 pin after one edge", {15'h0, reg_rdata[15]}, 16'h0);
      cyc(1);
      chk("R9 pin after two edges", {15'h0, reg_rdata[15]}, 16'h1);
      pin_in = 1'b0;
      cyc(3);

      // Table walk: R2 R3 R4 R5
      for (int v = 0; v < NV; v++) begin
         logic en, md, pl, st;
         int np, nt;
         string tag;
         {en, md, pl, st} = VEC[v][27:24];
         np = int'(VEC[v][23:16]);
         nt = int'(VEC[v][15:8]);
         tag = !en ? "R2" : (md ? "R5" : (pl ? "R3" : "R4"));
         pin_in = st; cyc(4);
         wr(2'b11, ctl(en, md, pl));
         pulse(np);
         ticks(nt);
         cyc(4);
         chk(tag, {8'h0, reg_rdata[7:0]}, {8'h0, VEC[v][7:0]});
      end

      // R10 control readback, reserved bits
      pin_in = 1'b1; cyc(4);
      wr(2'b11, ctl(1'b1, 1'b1, 1'b0));
      cyc(1);
      chk("R10 control readback", {8'h0, reg_rdata[14:8]}, 16'h0060);
      pin_in = 1'b0; cyc(4);
      wr(2'b10, ctl(1'b0, 1'b0, 1'b1));
      chk("R10 second readback", {8'h0, reg_rdata[14:8]}, 16'h0010);

      // R6 wrap and sticky overflow
      wr(2'b11, ctl(1'b1, 1'b0, 1'b1) | 16'h00FE);
      pulse(2);
      chk("R6 wrap value", {8'h0, reg_rdata[7:0]}, 16'h0000);
      chk("R6 overflow set", {15'h0, reg_rdata[11]}, 16'h1);
      pulse(1);
      chk("R6 overflow sticky", {15'h0, reg_rdata[11]}, 16'h1);
      wr(2'b10, {1'b0, 3'b101, 2'b10, 10'h0});
      chk("R6 overflow cleared", {15'h0, reg_rdata[11]}, 16'h0);
      chk("R6 count kept on clear", {8'h0, reg_rdata[7:0]}, 16'h0001);

      // R7 event flag, event mode
      wr(2'b10, ctl(1'b1, 1'b0, 1'b1));
      chk("R7 flag cleared", {15'h0, reg_rdata[10]}, 16'h0);
      pulse(1);
      chk("R7 flag on counted edge", {15'h0, reg_rdata[10]}, 16'h1);

      // R7 event flag, gated mode (pin low closed)
      wr(2'b11, ctl(1'b1, 1'b1, 1'b0));
      pin_in = 1'b1; cyc(4);
      chk("R7 no flag while gate open", {15'h0, reg_rdata[10]}, 16'h0);
      pin_in = 1'b0; cyc(2);
      chk("R7 no flag before close seen", {15'h0, reg_rdata[10]}, 16'h0);
      cyc(1);
      chk("R7 flag on gate close", {15'h0, reg_rdata[10]}, 16'h1);

      // R8 load beats a same-cycle increment
      wr(2'b11, ctl(1'b1, 1'b0, 1'b1) | 16'h0010);
      pin_in = 1'b1;
      cyc(2);
      wr(2'b01, 16'h0040);
      chk("R8 load wins", {8'h0, reg_rdata[7:0]}, 16'h0040);
      cyc(4);
      chk("R8 no late increment", {8'h0, reg_rdata[7:0]}, 16'h0040);
      pin_in = 1'b0; cyc(4);

      // R3 latency: count moves on the third edge
      pin_in = 1'b1; cyc(2);
      chk("R3 not yet counted", {8'h0, reg_rdata[7:0]}, 16'h0040);
      cyc(1);
      chk("R3 counted on third edge", {8'h0, reg_rdata[7:0]}, 16'h0041);

      // R2 disabled: pin and ticks change nothing
      wr(2'b10, ctl(1'b0, 1'b0, 1'b1));
      pulse(3); ticks(3);
      chk("R2 disabled hold", {8'h0, reg_rdata[7:0]}, 16'h0041);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule